// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block produces the chip-enable, write-enable and read-enable waveforms for one byte transfer on an 8-bit NAND bus. Every phase length is counted in controller clock cycles and is taken from a packed 26-bit timing word. A command or address sequencer above it hands over one byte request at a time. Each request names the direction, the write data and whether it closes the access. The block answers with a one-cycle done pulse. For a read, the captured byte appears on `rd_data`.

Before a strobe the generator inserts up to two waits. A chip-enable settle wait comes first, when chip enable was inactive. A bus turnaround wait follows when the direction differs from the previous byte. The block also masks the device ready/busy line for a programmed number of cycles after the sequencer signals a busy-causing command. This keeps the sequencer from sampling a stale ready level. The timing word must be held stable while a byte or a busy mask is in progress.

Top module: `nand_strobe_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to rest: `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `dq_oe` and `done` are 0, `req_ready` is 1, `rd_data` is 0, and `dev_ready` equals `rb_in`.
- R2: In a write byte, `nand_we_n` is low for L cycles and then high for H cycles before the block returns to idle. L comes from timing bits [3:0] and H from bits [7:4]. `done` is high only in the final high cycle.
- R3: In a read byte, `nand_re_n` is low for L cycles, with L from timing bits [11:8]. It is then high for H cycles, with H from bits [15:12]. `done` is high only in the final high cycle.
- R4: Any timing field holding zero gives a phase of exactly one cycle. A nonzero field gives exactly its value in cycles.
- R5: During a write byte, `dq_oe` is 1 and `dq_out` carries the request data for every low-phase and high-phase cycle. At all other times `dq_oe` is 0.
- R6: A read byte captures `dq_in` at the clock edge that ends the last low cycle of `nand_re_n`. `rd_data` shows that value from the following cycle until the next read capture.
- R7: A request accepted while chip enable is inactive drives `nand_ce_n` low in the next cycle. It then waits the number of cycles in timing bits [25:24] before the strobe phase or the turnaround wait.
- R8: When a byte's direction differs from the byte before it, both strobes stay high for the number of cycles in timing bits [18:16] before the low phase. This wait follows any chip-enable wait.
- R9: After the done cycle of a request marked `req_last`, `nand_ce_n` returns high. After any other request it stays low.
- R10: Raising `busy_start` for one cycle forces `dev_ready` low for the number of cycles in timing bits [23:19], starting in the next cycle. A new pulse during the mask restarts it. Outside the mask, `dev_ready` follows `rb_in`.
- R11: `req_ready` is high only while no byte is in progress, and a request is taken only when it is high. The two strobes are never low together, and no strobe goes low while `nand_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timing | input | 26 | Packed phase lengths in clock cycles |
| req_valid | input | 1 | A byte request is offered |
| req_ready | output | 1 | Generator is idle and takes a request |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_last | input | 1 | Release chip enable after this byte |
| req_data | input | 8 | Byte to drive for a write |
| done | output | 1 | One-cycle pulse in the final cycle of a byte |
| rd_data | output | 8 | Last byte captured by a read |
| busy_start | input | 1 | Pulse: a busy-causing command was issued |
| rb_in | input | 1 | Device ready/busy line, 1 = ready |
| dev_ready | output | 1 | Ready/busy after the post-command mask |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data bus value while driving |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | 8 | Data bus value from the device |

## Verification
Each phase is driven by a single down-counter, so an off-by-one load or a wrong zero decode shifts the next strobe edge and the `done` pulse by a full cycle. The cycle-by-cycle comparison catches this in the very byte where it occurs. A stale direction or chip-enable flag shows up as a missing or extra wait of idle strobes at the start of the next byte. A wrong capture point appears in `rd_data` one cycle after the read low phase ends. A busy counter that loads or releases badly makes `dev_ready` differ from `rb_in` at the first cycle past the programmed mask length.

// File: rtl/nstg_pkg.sv
// Shared definitions for the NAND strobe timing generator.
// Assumes a 26-bit packed timing word; each field is a cycle count.
package nstg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CEW,
        PH_TURN,
        PH_LOW,
        PH_HIGH
    } phase_t;

    localparam int CFG_W   = 26;
    localparam int CNT_W   = 4;
    localparam int BSY_W   = 5;

    localparam int WLO_LSB = 0;
    localparam int WHI_LSB = 4;
    localparam int RLO_LSB = 8;
    localparam int RHI_LSB = 12;
    localparam int TA_LSB  = 16;
    localparam int BSY_LSB = 19;
    localparam int CEA_LSB = 24;

    localparam int STB_W   = 4;
    localparam int TA_W    = 3;
    localparam int CEA_W   = 2;

    // Zero field means one cycle, so no phase is ever skipped.
    function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] f);
        return (f == '0) ? CNT_W'(1) : f;
    endfunction

    function automatic logic [BSY_W-1:0] eff_bsy(input logic [BSY_W-1:0] f);
        return (f == '0) ? BSY_W'(1) : f;
    endfunction

endpackage

// File: rtl/nstg_phase_seq.sv
// Phase sequencer: walks one byte through chip-enable wait, turnaround
// wait, strobe low and strobe high, with one shared down-counter.
// Assumes cfg is stable while a byte is in progress.
module nstg_phase_seq
    import nstg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_last,
    output logic             req_ready,
    output logic             accept,
    output logic             done,
    output logic             ce_on,
    output logic             we_low,
    output logic             re_low,
    output logic             drive_bus,
    output logic             sample
);

    phase_t           ph, ph_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             wr_q, last_q, turn_q, ce_q, have_dir_q, dir_q;
    logic             turn_now, cnt_zero;

    logic [CNT_W-1:0] len_wlo, len_whi, len_rlo, len_rhi, len_ta, len_cea;

    // Decode effective phase lengths from the packed timing word.
    always_comb begin
        len_wlo = eff_cnt(cfg[WLO_LSB +: STB_W]);
        len_whi = eff_cnt(cfg[WHI_LSB +: STB_W]);
        len_rlo = eff_cnt(cfg[RLO_LSB +: STB_W]);
        len_rhi = eff_cnt(cfg[RHI_LSB +: STB_W]);
        len_ta  = eff_cnt({{(CNT_W-TA_W){1'b0}}, cfg[TA_LSB +: TA_W]});
        len_cea = eff_cnt({{(CNT_W-CEA_W){1'b0}}, cfg[CEA_LSB +: CEA_W]});
    end

    assign accept   = req_valid && (ph == PH_IDLE);
    assign turn_now = have_dir_q && (dir_q != req_write);
    assign cnt_zero = (cnt == '0);

    // Next phase and counter load.
    always_comb begin
        ph_nx  = ph;
        cnt_nx = cnt_zero ? cnt : cnt - CNT_W'(1);
        case (ph)
            PH_IDLE: begin
                if (accept) begin
                    if (!ce_q) begin
                        ph_nx  = PH_CEW;
                        cnt_nx = len_cea - CNT_W'(1);
                    end else if (turn_now) begin
                        ph_nx  = PH_TURN;
                        cnt_nx = len_ta - CNT_W'(1);
                    end else begin
                        ph_nx  = PH_LOW;
                        cnt_nx = (req_write ? len_wlo : len_rlo) - CNT_W'(1);
                    end
                end
            end
            PH_CEW: begin
                if (cnt_zero) begin
                    if (turn_q) begin
                        ph_nx  = PH_TURN;
                        cnt_nx = len_ta - CNT_W'(1);
                    end else begin
                        ph_nx  = PH_LOW;
                        cnt_nx = (wr_q ? len_wlo : len_rlo) - CNT_W'(1);
                    end
                end
            end
            PH_TURN: begin
                if (cnt_zero) begin
                    ph_nx  = PH_LOW;
                    cnt_nx = (wr_q ? len_wlo : len_rlo) - CNT_W'(1);
                end
            end
            PH_LOW: begin
                if (cnt_zero) begin
                    ph_nx  = PH_HIGH;
                    cnt_nx = (wr_q ? len_whi : len_rhi) - CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (cnt_zero) begin
                    ph_nx  = PH_IDLE;
                    cnt_nx = '0;
                end
            end
            default: begin
                ph_nx  = PH_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    // Phase, counter and per-byte flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= PH_IDLE;
            cnt        <= '0;
            wr_q       <= 1'b0;
            last_q     <= 1'b0;
            turn_q     <= 1'b0;
            ce_q       <= 1'b0;
            have_dir_q <= 1'b0;
            dir_q      <= 1'b0;
        end else begin
            ph  <= ph_nx;
            cnt <= cnt_nx;
            if (accept) begin
                wr_q       <= req_write;
                last_q     <= req_last;
                turn_q     <= turn_now;
                ce_q       <= 1'b1;
                have_dir_q <= 1'b1;
                dir_q      <= req_write;
            end else if (ph == PH_HIGH && cnt_zero && last_q) begin
                ce_q <= 1'b0;
            end
        end
    end

    assign req_ready = (ph == PH_IDLE);
    assign done      = (ph == PH_HIGH) && cnt_zero;
    assign ce_on     = ce_q;
    assign we_low    = (ph == PH_LOW) && wr_q;
    assign re_low    = (ph == PH_LOW) && !wr_q;
    assign drive_bus = wr_q && (ph == PH_LOW || ph == PH_HIGH);
    assign sample    = (ph == PH_LOW) && cnt_zero && !wr_q;

endmodule

// File: rtl/nstg_data_path.sv
// Data path: holds the write byte from acceptance to the end of the byte
// and captures the read byte on the sequencer's sample strobe.
// Assumes sample is high only in the final read-low cycle.
module nstg_data_path #(
    parameter int DQ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [DQ_W-1:0] req_data,
    input  logic            drive_bus,
    input  logic            sample,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe,
    output logic [DQ_W-1:0] rd_data
);

    logic [DQ_W-1:0] wdata_q;
    logic [DQ_W-1:0] rdata_q;

    // Latch write data at acceptance; capture read data at sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) wdata_q <= req_data;
            if (sample) rdata_q <= dq_in;
        end
    end

    assign dq_out  = wdata_q;
    assign dq_oe   = drive_bus;
    assign rd_data = rdata_q;

endmodule

// File: rtl/nstg_busy_mask.sv
// Busy mask: after a busy-causing command, hides the ready/busy line for
// a programmed number of cycles. A new pulse restarts the mask.
module nstg_busy_mask
    import nstg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_start,
    input  logic [BSY_W-1:0] mask_len,
    input  logic             rb_in,
    output logic             dev_ready
);

    logic [BSY_W-1:0] left_q;

    // Load on pulse, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               left_q <= '0;
        else if (busy_start)      left_q <= eff_bsy(mask_len);
        else if (left_q != '0)    left_q <= left_q - BSY_W'(1);
    end

    assign dev_ready = rb_in && (left_q == '0);

endmodule

// File: rtl/nand_strobe_gen.sv
// NAND strobe timing generator top: ties the phase sequencer, data path
// and busy mask to the NAND pins. Takes one byte request at a time.
module nand_strobe_gen
    import nstg_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_timing,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_last,
    input  logic [DQ_W-1:0]  req_data,
    output logic             done,
    output logic [DQ_W-1:0]  rd_data,
    input  logic             busy_start,
    input  logic             rb_in,
    output logic             dev_ready,
    output logic             nand_ce_n,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe,
    input  logic [DQ_W-1:0]  dq_in
);

    logic accept, ce_on, we_low, re_low, drive_bus, sample;

    nstg_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_timing),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_last  (req_last),
        .req_ready (req_ready),
        .accept    (accept),
        .done      (done),
        .ce_on     (ce_on),
        .we_low    (we_low),
        .re_low    (re_low),
        .drive_bus (drive_bus),
        .sample    (sample)
    );

    nstg_data_path #(.DQ_W(DQ_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_data  (req_data),
        .drive_bus (drive_bus),
        .sample    (sample),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .rd_data   (rd_data)
    );

    nstg_busy_mask u_bsy (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_start (busy_start),
        .mask_len   (cfg_timing[BSY_LSB +: BSY_W]),
        .rb_in      (rb_in),
        .dev_ready  (dev_ready)
    );

    assign nand_ce_n = !ce_on;
    assign nand_we_n = !we_low;
    assign nand_re_n = !re_low;

endmodule

// File: rtl/nand_strobe_gen_chk.sv
// Port-level protocol checks for nand_strobe_gen, bound to every instance.
module nand_strobe_gen_chk #(
    parameter int DQ_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            done,
    input logic            busy_start,
    input logic            dev_ready,
    input logic            nand_ce_n,
    input logic            nand_we_n,
    input logic            nand_re_n,
    input logic [DQ_W-1:0] dq_out,
    input logic            dq_oe
);

    // R11: strobes are never low together
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R11: a strobe is low only with chip enable active
    p_strobe_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R11: acceptance closes the request port in the next cycle
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: write strobe low only while the bus is driven
    p_we_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> dq_oe);

    // R5: driven data does not change within a byte
    p_dq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    // R2: done lasts a single cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: chip enable is active right after acceptance
    p_ce_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !nand_ce_n);

    // R10: a busy pulse masks ready in the next cycle
    p_busy_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_start |=> !dev_ready);

endmodule

bind nand_strobe_gen nand_strobe_gen_chk #(.DQ_W(DQ_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .busy_start (busy_start),
    .dev_ready  (dev_ready),
    .nand_ce_n  (nand_ce_n),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
);

// File: tb/nand_strobe_gen_tb.sv
// Bench: behavioural per-cycle schedule model in a queue, compared with
// the DUT on every falling clock edge. Inputs change 1 ns after rising edges.
module nand_strobe_gen_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [25:0] cfg_timing = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_last = 1'b0;
    logic [7:0]  req_data = '0;
    logic        busy_start = 1'b0;
    logic        rb_in = 1'b1;
    logic [7:0]  dq_in = 8'h11;
    logic        req_ready, done, dev_ready, nand_ce_n, nand_we_n, nand_re_n, dq_oe;
    logic [7:0]  rd_data, dq_out;

    int errs = 0;
    int checks = 0;
    bit run = 0;
    bit finished = 0;

    nand_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_last(req_last), .req_data(req_data), .done(done), .rd_data(rd_data),
        .busy_start(busy_start), .rb_in(rb_in), .dev_ready(dev_ready),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    initial forever #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int eff(input int f);
        return (f == 0) ? 1 : f;
    endfunction

    function automatic logic [25:0] mk_cfg(input int cea, input int bsy, input int ta,
                                           input int rhi, input int rlo,
                                           input int whi, input int wlo);
        return {cea[1:0], bsy[4:0], ta[2:0], rhi[3:0], rlo[3:0], whi[3:0], wlo[3:0]};
    endfunction

    // Entry bits: 0 ce_n, 1 we_n, 2 re_n, 3 oe, 4 done, 5 sample, 15:8 data
    function automatic int ent(input bit ce_n, input bit we_n, input bit re_n,
                               input bit oe, input bit dn, input bit smp, input logic [7:0] d);
        return {16'd0, d, 2'b00, smp, dn, oe, re_n, we_n, ce_n};
    endfunction

    int   q[$];
    bit   ce_on_m = 0, have_m = 0, dir_m = 0;
    logic [7:0] rd_m = '0, rd_pend = '0;
    bit   rd_pend_v = 0;
    int   bleft = 0;
    bit   acc_p = 0, bsy_p = 0, acc_w = 0, acc_l = 0;
    logic [7:0] acc_d = '0;

    function automatic void push_byte(input bit w, input bit l, input logic [7:0] d);
        int lo, hi;
        if (!ce_on_m)
            for (int i = 0; i < eff(int'(cfg_timing[25:24])); i++)
                q.push_back(ent(0, 1, 1, 0, 0, 0, d));
        if (have_m && dir_m != w)
            for (int i = 0; i < eff(int'(cfg_timing[18:16])); i++)
                q.push_back(ent(0, 1, 1, 0, 0, 0, d));
        lo = w ? eff(int'(cfg_timing[3:0]))  : eff(int'(cfg_timing[11:8]));
        hi = w ? eff(int'(cfg_timing[7:4]))  : eff(int'(cfg_timing[15:12]));
        for (int i = 0; i < lo; i++)
            q.push_back(ent(0, !w, w, w, 0, (!w) && (i == lo - 1), d));
        for (int i = 0; i < hi; i++)
            q.push_back(ent(0, 1, 1, w, i == hi - 1, 0, d));
        ce_on_m = !l;
        have_m  = 1;
        dir_m   = w;
    endfunction

    // Reference model step and comparison on every falling edge.
    initial forever begin
        @(negedge clk);
        if (run && !finished) begin
            int e;
            bit exp_rdy;
            if (acc_p) push_byte(acc_w, acc_l, acc_d);
            if (bsy_p) bleft = eff(int'(cfg_timing[23:19]));
            else if (bleft > 0) bleft--;
            if (rd_pend_v) begin rd_m = rd_pend; rd_pend_v = 0; end
            if (q.size() > 0) begin e = q.pop_front(); exp_rdy = 0; end
            else begin e = ent(!ce_on_m, 1, 1, 0, 0, 0, 8'h00); exp_rdy = 1; end
            chk(nand_ce_n == e[0], "R7/R9", "ce_n", nand_ce_n, e[0]);
            chk(nand_we_n == e[1], "R2/R4", "we_n", nand_we_n, e[1]);
            chk(nand_re_n == e[2], "R3/R8", "re_n", nand_re_n, e[2]);
            chk(dq_oe == e[3], "R5", "dq_oe", dq_oe, e[3]);
            if (e[3]) chk(dq_out == e[15:8], "R5", "dq_out", dq_out, e[15:8]);
            chk(done == e[4], "R2/R3", "done", done, e[4]);
            chk(req_ready == exp_rdy, "R11", "req_ready", req_ready, exp_rdy);
            chk(dev_ready == (rb_in && bleft == 0), "R10", "dev_ready",
                dev_ready, rb_in && bleft == 0);
            chk(rd_data == rd_m, "R6", "rd_data", rd_data, rd_m);
            if (e[5]) begin rd_pend = dq_in; rd_pend_v = 1; end
            acc_p = req_valid && exp_rdy;
            acc_w = req_write;
            acc_l = req_last;
            acc_d = req_data;
            bsy_p = busy_start;
        end
    end

    // Data bus from the device changes every cycle.
    initial forever begin
        @(posedge clk);
        #1 dq_in = dq_in + 8'h35;
    end

    task automatic send(input bit w, input bit l, input logic [7:0] d);
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        req_valid = 1; req_write = w; req_last = l; req_data = d;
        @(posedge clk); #1;
        req_valid = 0; req_data = 8'hxx === 8'h00 ? 8'h00 : 8'hA5;
        while (!req_ready) begin @(posedge clk); #1; end
    endtask

    task automatic busy_pulse();
        @(posedge clk); #1 busy_start = 1;
        @(posedge clk); #1 busy_start = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cfg_timing = mk_cfg(1, 5, 2, 1, 4, 3, 2);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: rest state while in reset
        chk(nand_ce_n === 1'b1, "R1", "ce_n", nand_ce_n, 1);
        chk(nand_we_n === 1'b1, "R1", "we_n", nand_we_n, 1);
        chk(nand_re_n === 1'b1, "R1", "re_n", nand_re_n, 1);
        chk(dq_oe === 1'b0, "R1", "dq_oe", dq_oe, 0);
        chk(done === 1'b0, "R1", "done", done, 0);
        chk(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
        chk(rd_data === 8'h00, "R1", "rd_data", rd_data, 0);
        chk(dev_ready === rb_in, "R1", "dev_ready", dev_ready, rb_in);
        @(posedge clk); #1 rst_n = 1; run = 1;

        // R2 R5 R7 R8 R9: writes, direction change, reads, release
        send(1, 0, 8'h3C);
        send(1, 0, 8'hC3);
        send(0, 0, 8'h00);
        send(0, 1, 8'h00);
        idle(3);
        send(1, 1, 8'h5A);
        idle(2);

        // R4: all fields zero give one-cycle phases
        cfg_timing = '0;
        send(1, 0, 8'h81);
        send(0, 1, 8'h00);
        send(0, 0, 8'h00);
        send(1, 1, 8'h7E);
        busy_pulse();
        idle(3);

        // R3 R6 R8: longest fields
        cfg_timing = mk_cfg(3, 31, 7, 15, 15, 15, 15);
        send(0, 0, 8'h00);
        send(1, 0, 8'hF0);
        send(1, 1, 8'h0F);
        idle(2);

        // R10: busy mask with ready high, low and a restart
        cfg_timing = mk_cfg(2, 6, 1, 2, 3, 1, 1);
        busy_pulse();
        idle(10);
        rb_in = 0;
        busy_pulse();
        idle(3);
        busy_pulse();
        idle(4);
        rb_in = 1;
        idle(6);
        busy_pulse();
        send(0, 1, 8'h00);
        idle(4);
        finish_run();
    end

endmodule